// File: doc/BRIEF.md
# Shared-RAM Partitioned FIFO Controller

This block splits one single-port data RAM into three circular FIFOs: a receive FIFO, a non-periodic transmit FIFO and a periodic transmit FIFO. Two masters use it. The bus side pushes transmit words and pops receive words. The link side pops transmit words and pushes receive words. Three configuration words place and size the regions at run time. The receive region is always anchored at RAM word 0, and only its size can be set. Each transmit region has its own base and its own size.

Every region keeps its own write pointer, read pointer and occupancy count. A physical address is the region base plus the local pointer. The pointer returns to zero after it reaches the last word of the region. A fixed-priority arbiter hands the RAM to at most one access per cycle. A request that loses is stalled: its ready stays low until the request is granted. A push into a full region or a pop from an empty region still takes its grant, but it leaves the RAM and the counts alone and raises an error pulse. Popped data appears one cycle after the grant, marked by a data-valid strobe.

Top module: `shram_fifo_ctrl`

## Requirements
- R1: After reset every region has used count 0, its free count equal to its configured depth, empty high and full low.
- R2: Words pushed by the link into the receive region are returned in push order on the bus pop port. `bus_rx_pop_dvalid` rises in the cycle after `bus_rx_pop_ready`, and the word is on `bus_rx_pop_data` in that same cycle.
- R3: In each configuration word, bits [31:16] hold the region depth in words. For the two transmit regions, bits [15:0] hold the base address. The receive region always starts at address 0, and bits [15:0] of its word are ignored.
- R4: A region's pointers wrap from depth-1 back to 0. Data keeps FIFO order across the wrap and never touches words outside the region. Link pops are returned on `lnk_pop_data` with `lnk_pop_dvalid` one cycle after the grant.
- R5: Array index 0 is the receive region, 1 the non-periodic transmit region and 2 the periodic transmit region. For each region, `rg_used` is the number of words stored and `rg_free` is depth minus used. Full means used equals depth, and empty means used is 0.
- R6: A granted push into a full region, or a granted pop from an empty region, changes no count and produces no data-valid. In the grant cycle it raises the bit of that region in `err_push_full` or `err_pop_empty`.
- R7: At most one request is granted per cycle. The priority, highest first, is: link receive push, link non-periodic pop, link periodic pop, bus transmit push, bus receive pop. A request that is not granted sees ready low and stays pending.
- R8: A bus transmit push goes to the non-periodic region when `bus_tx_push_sel` is 0 and to the periodic region when it is 1.
- R9: When a configuration word differs from the value seen in the previous cycle, that region's pointers and count are cleared at the next clock edge. The other regions are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rx | input | 32 | Receive region configuration word (depth in [31:16]) |
| cfg_np | input | 32 | Non-periodic transmit configuration word (depth [31:16], base [15:0]) |
| cfg_pt | input | 32 | Periodic transmit configuration word (depth [31:16], base [15:0]) |
| lnk_rx_push_valid | input | 1 | Link request to push one receive word |
| lnk_rx_push_data | input | DW | Receive word to push |
| lnk_rx_push_ready | output | 1 | Link receive push granted this cycle |
| lnk_np_pop_req | input | 1 | Link request to pop a non-periodic transmit word |
| lnk_np_pop_ready | output | 1 | Non-periodic pop granted this cycle |
| lnk_pt_pop_req | input | 1 | Link request to pop a periodic transmit word |
| lnk_pt_pop_ready | output | 1 | Periodic pop granted this cycle |
| lnk_pop_dvalid | output | 1 | `lnk_pop_data` holds a popped transmit word |
| lnk_pop_data | output | DW | Popped transmit word |
| bus_tx_push_valid | input | 1 | Bus request to push one transmit word |
| bus_tx_push_sel | input | 1 | Target transmit region: 0 non-periodic, 1 periodic |
| bus_tx_push_data | input | DW | Transmit word to push |
| bus_tx_push_ready | output | 1 | Bus transmit push granted this cycle |
| bus_rx_pop_req | input | 1 | Bus request to pop one receive word |
| bus_rx_pop_ready | output | 1 | Bus receive pop granted this cycle |
| bus_rx_pop_dvalid | output | 1 | `bus_rx_pop_data` holds a popped receive word |
| bus_rx_pop_data | output | DW | Popped receive word |
| rg_used | output | 3x16 | Words stored per region |
| rg_free | output | 3x16 | Free words per region |
| rg_full | output | 3 | Region full flags |
| rg_empty | output | 3 | Region empty flags |
| err_push_full | output | 3 | Pulse: a granted push hit a full region |
| err_pop_empty | output | 3 | Pulse: a granted pop hit an empty region |

## Verification
If a pointer wraps at the wrong point, or an address is computed from the wrong base, the damage first shows up as a wrong word on the next pop from the affected region. That pop can come many cycles after the bad write, which is why the bench fills regions that sit next to each other before it drains them. A count that drifts shows up in `rg_used` and `rg_free` at the very next clock edge, because both are compared against a queue model in every cycle. An arbitration fault shows up in the same cycle as a ready on the wrong port, and one cycle later as a data-valid strobe that the model does not expect.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
   localparam int FLD_W = 16;
   localparam int CFG_W = 32;
   localparam int NRG   = 3;
   localparam int RG_RX = 0;
   localparam int RG_NP = 1;
   localparam int RG_PT = 2;
   // request slots, index order is the grant priority (lowest index wins)
   localparam int NREQ       = 5;
   localparam int RQ_RXPUSH  = 0;
   localparam int RQ_NPPOP   = 1;
   localparam int RQ_PTPOP   = 2;
   localparam int RQ_TXPUSH  = 3;
   localparam int RQ_RXPOP   = 4;

   function automatic logic [FLD_W-1:0] cfg_depth(input logic [CFG_W-1:0] w);
      return w[CFG_W-1:FLD_W];
   endfunction

   function automatic logic [FLD_W-1:0] cfg_base(input logic [CFG_W-1:0] w);
      return w[FLD_W-1:0];
   endfunction
endpackage

// File: rtl/sfc_arbiter.sv
module sfc_arbiter #(
   parameter int N = 5
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   if (N < 1) begin : g_bad_n
      $error("sfc_arbiter: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_slot
      if (i == 0) begin : g_top
         assign gnt[i] = req[i];
      end else begin : g_low
         assign gnt[i] = req[i] & ~(|req[i-1:0]);
      end
   end
endmodule

// File: rtl/sfc_spram.sv
module sfc_spram #(
   parameter int AW = 10,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          en,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int WORDS = 1 << AW;

   logic [DW-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem[addr] <= wdata;
         else    rdata     <= mem[addr];
      end
   end
endmodule

// File: rtl/sfc_region.sv
module sfc_region
   import sfc_pkg::*;
#(
   parameter int AW         = 10,
   parameter bit FIXED_BASE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] cfg,
   input  logic             push_go,
   input  logic             pop_go,
   output logic [AW-1:0]    wr_addr,
   output logic [AW-1:0]    rd_addr,
   output logic [FLD_W-1:0] used,
   output logic [FLD_W-1:0] free,
   output logic             full,
   output logic             empty
);
   if (AW < 1 || AW > FLD_W) begin : g_bad_aw
      $error("sfc_region: AW must lie in 1..16");
   end

   logic [CFG_W-1:0] cfg_q;
   logic [FLD_W-1:0] wp, rp, cnt, depth, base, wsum, rsum;
   logic             cfg_chg, push_ok, pop_ok;

   assign depth   = cfg_depth(cfg_q);
   assign cfg_chg = (cfg != cfg_q);

   if (FIXED_BASE) begin : g_fixed
      assign base = '0;
   end else begin : g_cfg
      assign base = cfg_base(cfg_q);
   end

   assign wsum    = base + wp;
   assign rsum    = base + rp;
   assign wr_addr = wsum[AW-1:0];
   assign rd_addr = rsum[AW-1:0];

   assign full    = (cnt == depth);
   assign empty   = (cnt == '0);
   assign used    = cnt;
   assign free    = depth - cnt;
   assign push_ok = push_go & ~full;
   assign pop_ok  = pop_go & ~empty;

   function automatic logic [FLD_W-1:0] step(input logic [FLD_W-1:0] p,
                                             input logic [FLD_W-1:0] d);
      return (p == d - 1'b1) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= cfg;
         wp    <= '0;
         rp    <= '0;
         cnt   <= '0;
      end else if (cfg_chg) begin
         cfg_q <= cfg;
         wp    <= '0;
         rp    <= '0;
         cnt   <= '0;
      end else begin
         if (push_ok) wp <= step(wp, depth);
         if (pop_ok)  rp <= step(rp, depth);
         case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   AST_USED_LE_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
      used <= cfg_depth(cfg_q));                                       // R5
   AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !cfg_chg) |=> (used <= $past(used)));                   // R6
   AST_EMPTY_NO_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !cfg_chg) |=> (used >= $past(used)));                  // R6
   AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_chg |=> (used == '0));                                       // R9
endmodule

// File: rtl/shram_fifo_ctrl.sv
module shram_fifo_ctrl
   import sfc_pkg::*;
#(
   parameter int AW = 10,
   parameter int DW = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [31:0]           cfg_rx,
   input  logic [31:0]           cfg_np,
   input  logic [31:0]           cfg_pt,
   input  logic                  lnk_rx_push_valid,
   input  logic [DW-1:0]         lnk_rx_push_data,
   output logic                  lnk_rx_push_ready,
   input  logic                  lnk_np_pop_req,
   output logic                  lnk_np_pop_ready,
   input  logic                  lnk_pt_pop_req,
   output logic                  lnk_pt_pop_ready,
   output logic                  lnk_pop_dvalid,
   output logic [DW-1:0]         lnk_pop_data,
   input  logic                  bus_tx_push_valid,
   input  logic                  bus_tx_push_sel,
   input  logic [DW-1:0]         bus_tx_push_data,
   output logic                  bus_tx_push_ready,
   input  logic                  bus_rx_pop_req,
   output logic                  bus_rx_pop_ready,
   output logic                  bus_rx_pop_dvalid,
   output logic [DW-1:0]         bus_rx_pop_data,
   output logic [2:0][15:0]      rg_used,
   output logic [2:0][15:0]      rg_free,
   output logic [2:0]            rg_full,
   output logic [2:0]            rg_empty,
   output logic [2:0]            err_push_full,
   output logic [2:0]            err_pop_empty
);
   if (DW < 1) begin : g_bad_dw
      $error("shram_fifo_ctrl: DW must be positive");
   end

   logic [NREQ-1:0]     req, gnt;
   logic [NRG-1:0]      push_go, pop_go, push_ok, pop_ok;
   logic [CFG_W-1:0]    cfg_w   [NRG];
   logic [AW-1:0]       wr_addr [NRG];
   logic [AW-1:0]       rd_addr [NRG];
   logic                ram_en, ram_we;
   logic [AW-1:0]       ram_addr;
   logic [DW-1:0]       ram_wdata, ram_rdata;

   assign req[RQ_RXPUSH] = lnk_rx_push_valid;
   assign req[RQ_NPPOP]  = lnk_np_pop_req;
   assign req[RQ_PTPOP]  = lnk_pt_pop_req;
   assign req[RQ_TXPUSH] = bus_tx_push_valid;
   assign req[RQ_RXPOP]  = bus_rx_pop_req;

   sfc_arbiter #(.N(NREQ)) u_arb (.req(req), .gnt(gnt));

   assign lnk_rx_push_ready = gnt[RQ_RXPUSH];
   assign lnk_np_pop_ready  = gnt[RQ_NPPOP];
   assign lnk_pt_pop_ready  = gnt[RQ_PTPOP];
   assign bus_tx_push_ready = gnt[RQ_TXPUSH];
   assign bus_rx_pop_ready  = gnt[RQ_RXPOP];

   assign push_go[RG_RX] = gnt[RQ_RXPUSH];
   assign push_go[RG_NP] = gnt[RQ_TXPUSH] & ~bus_tx_push_sel;
   assign push_go[RG_PT] = gnt[RQ_TXPUSH] &  bus_tx_push_sel;
   assign pop_go[RG_RX]  = gnt[RQ_RXPOP];
   assign pop_go[RG_NP]  = gnt[RQ_NPPOP];
   assign pop_go[RG_PT]  = gnt[RQ_PTPOP];

   assign cfg_w[RG_RX] = cfg_rx;
   assign cfg_w[RG_NP] = cfg_np;
   assign cfg_w[RG_PT] = cfg_pt;

   for (genvar g = 0; g < NRG; g++) begin : g_rg
      sfc_region #(.AW(AW), .FIXED_BASE(g == RG_RX)) u_rg (
         .clk     (clk),
         .rst_n   (rst_n),
         .cfg     (cfg_w[g]),
         .push_go (push_go[g]),
         .pop_go  (pop_go[g]),
         .wr_addr (wr_addr[g]),
         .rd_addr (rd_addr[g]),
         .used    (rg_used[g]),
         .free    (rg_free[g]),
         .full    (rg_full[g]),
         .empty   (rg_empty[g])
      );
      assign push_ok[g]       = push_go[g] & ~rg_full[g];
      assign pop_ok[g]        = pop_go[g]  & ~rg_empty[g];
      assign err_push_full[g] = push_go[g] &  rg_full[g];
      assign err_pop_empty[g] = pop_go[g]  &  rg_empty[g];
   end

   always_comb begin
      ram_addr = '0;
      for (int g = 0; g < NRG; g++) begin
         if (push_ok[g]) ram_addr = wr_addr[g];
         if (pop_ok[g])  ram_addr = rd_addr[g];
      end
   end

   assign ram_we    = |push_ok;
   assign ram_en    = ram_we | (|pop_ok);
   assign ram_wdata = gnt[RQ_RXPUSH] ? lnk_rx_push_data : bus_tx_push_data;

   sfc_spram #(.AW(AW), .DW(DW)) u_ram (
      .clk   (clk),
      .en    (ram_en),
      .we    (ram_we),
      .addr  (ram_addr),
      .wdata (ram_wdata),
      .rdata (ram_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lnk_pop_dvalid    <= 1'b0;
         bus_rx_pop_dvalid <= 1'b0;
      end else begin
         lnk_pop_dvalid    <= pop_ok[RG_NP] | pop_ok[RG_PT];
         bus_rx_pop_dvalid <= pop_ok[RG_RX];
      end
   end

   assign lnk_pop_data    = ram_rdata;
   assign bus_rx_pop_data = ram_rdata;

   AST_ONE_RAM_OP: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({push_ok, pop_ok}));                                     // R7
   AST_LINK_BEATS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (lnk_rx_push_valid && bus_tx_push_valid) |-> !bus_tx_push_ready); // R7
   AST_RX_DVALID_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rx_pop_dvalid |-> $past(bus_rx_pop_ready));                   // R2
   AST_LNK_DVALID_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      lnk_pop_dvalid |-> ($past(lnk_np_pop_ready) || $past(lnk_pt_pop_ready))); // R4
endmodule

// File: tb/tb_shram_fifo_ctrl.sv
`timescale 1ns/1ps
module tb_shram_fifo_ctrl;
   localparam int AW = 10;
   localparam int DW = 32;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n;
   logic [31:0] cfg_rx, cfg_np, cfg_pt;
   logic l_rxv, l_np, l_pt, b_txv, b_sel, b_rxp;
   logic [DW-1:0] l_rxd, b_txd;
   logic lnk_rx_push_ready, lnk_np_pop_ready, lnk_pt_pop_ready, lnk_pop_dvalid;
   logic bus_tx_push_ready, bus_rx_pop_ready, bus_rx_pop_dvalid;
   logic [DW-1:0] lnk_pop_data, bus_rx_pop_data;
   logic [2:0][15:0] rg_used, rg_free;
   logic [2:0] rg_full, rg_empty, err_push_full, err_pop_empty;

   shram_fifo_ctrl #(.AW(AW), .DW(DW)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_rx(cfg_rx), .cfg_np(cfg_np), .cfg_pt(cfg_pt),
      .lnk_rx_push_valid(l_rxv), .lnk_rx_push_data(l_rxd), .lnk_rx_push_ready(lnk_rx_push_ready),
      .lnk_np_pop_req(l_np), .lnk_np_pop_ready(lnk_np_pop_ready),
      .lnk_pt_pop_req(l_pt), .lnk_pt_pop_ready(lnk_pt_pop_ready),
      .lnk_pop_dvalid(lnk_pop_dvalid), .lnk_pop_data(lnk_pop_data),
      .bus_tx_push_valid(b_txv), .bus_tx_push_sel(b_sel), .bus_tx_push_data(b_txd),
      .bus_tx_push_ready(bus_tx_push_ready),
      .bus_rx_pop_req(b_rxp), .bus_rx_pop_ready(bus_rx_pop_ready),
      .bus_rx_pop_dvalid(bus_rx_pop_dvalid), .bus_rx_pop_data(bus_rx_pop_data),
      .rg_used(rg_used), .rg_free(rg_free), .rg_full(rg_full), .rg_empty(rg_empty),
      .err_push_full(err_push_full), .err_pop_empty(err_pop_empty)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // reference model
   logic [31:0] q_rx[$], q_np[$], q_pt[$];
   logic [31:0] m_cfg[3];
   bit          e_bdv = 0, e_ldv = 0;
   logic [31:0] e_bd = '0, e_ld = '0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic int qsz(input int g);
      return (g == 0) ? q_rx.size() : (g == 1) ? q_np.size() : q_pt.size();
   endfunction

   function automatic int dep(input int g);
      return int'(m_cfg[g][31:16]);
   endfunction

   task automatic qpush(input int g, input logic [31:0] d);
      if (g == 0) q_rx.push_back(d);
      else if (g == 1) q_np.push_back(d);
      else q_pt.push_back(d);
   endtask

   task automatic qpop(input int g, output logic [31:0] d);
      if (g == 0) d = q_rx.pop_front();
      else if (g == 1) d = q_np.pop_front();
      else d = q_pt.pop_front();
   endtask

   // called at a negedge with inputs already applied; checks, then updates model
   task automatic tick();
      logic [4:0] rq, eg, ag;
      logic [2:0] epf, epe;
      logic [31:0] cfg_now[3];
      logic [31:0] d;
      int pg, og;
      #1;
      for (int g = 0; g < 3; g++) begin
         chk(rg_used[g] == 16'(qsz(g)), "R5 used", rg_used[g], qsz(g));
         chk(rg_free[g] == 16'(dep(g) - qsz(g)), "R5 free", rg_free[g], dep(g) - qsz(g));
         chk(rg_full[g] == (qsz(g) == dep(g)), "R5 full", rg_full[g], qsz(g) == dep(g));
         chk(rg_empty[g] == (qsz(g) == 0), "R5 empty", rg_empty[g], qsz(g) == 0);
      end
      chk(bus_rx_pop_dvalid == e_bdv, "R2 bus dvalid", bus_rx_pop_dvalid, e_bdv);
      if (e_bdv) chk(bus_rx_pop_data == e_bd, "R2 R3 rx data", bus_rx_pop_data, e_bd);
      chk(lnk_pop_dvalid == e_ldv, "R4 link dvalid", lnk_pop_dvalid, e_ldv);
      if (e_ldv) chk(lnk_pop_data == e_ld, "R3 R4 R8 tx data", lnk_pop_data, e_ld);
      rq = {b_rxp, b_txv, l_pt, l_np, l_rxv};
      eg = '0;
      for (int i = 0; i < 5; i++) if (rq[i]) begin eg[i] = 1'b1; break; end
      ag = {bus_rx_pop_ready, bus_tx_push_ready, lnk_pt_pop_ready, lnk_np_pop_ready, lnk_rx_push_ready};
      chk(ag == eg, "R7 grants", ag, eg);
      pg = -1; og = -1;
      if (eg[0]) pg = 0;
      if (eg[3]) pg = b_sel ? 2 : 1;
      if (eg[1]) og = 1;
      if (eg[2]) og = 2;
      if (eg[4]) og = 0;
      epf = '0; epe = '0;
      if (pg >= 0 && qsz(pg) == dep(pg)) epf[pg] = 1'b1;
      if (og >= 0 && qsz(og) == 0) epe[og] = 1'b1;
      chk(err_push_full == epf, "R6 push err", err_push_full, epf);
      chk(err_pop_empty == epe, "R6 pop err", err_pop_empty, epe);
      // model update for the coming edge
      e_bdv = 0; e_ldv = 0;
      if (pg >= 0 && !epf[pg]) qpush(pg, eg[0] ? l_rxd : b_txd);
      if (og >= 0 && !epe[og]) begin
         qpop(og, d);
         if (og == 0) begin e_bdv = 1; e_bd = d; end
         else begin e_ldv = 1; e_ld = d; end
      end
      cfg_now[0] = cfg_rx; cfg_now[1] = cfg_np; cfg_now[2] = cfg_pt;
      for (int g = 0; g < 3; g++) if (cfg_now[g] != m_cfg[g]) begin  // R9
         m_cfg[g] = cfg_now[g];
         if (g == 0) q_rx.delete(); else if (g == 1) q_np.delete(); else q_pt.delete();
      end
      @(negedge clk);
   endtask

   task automatic idle();
      l_rxv = 0; l_np = 0; l_pt = 0; b_txv = 0; b_rxp = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 0; idle(); b_sel = 0; l_rxd = '0; b_txd = '0;
      cfg_rx = {16'd16, 16'h0010};      // low half points at np base: must be ignored (R3)
      cfg_np = {16'd8, 16'd16};
      cfg_pt = {16'd8, 16'd24};
      m_cfg[0] = cfg_rx; m_cfg[1] = cfg_np; m_cfg[2] = cfg_pt;
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      for (int g = 0; g < 3; g++) begin  // R1
         chk(rg_used[g] == 0, "R1 used", rg_used[g], 0);
         chk(rg_free[g] == m_cfg[g][31:16], "R1 free", rg_free[g], m_cfg[g][31:16]);
         chk(rg_empty[g] && !rg_full[g], "R1 flags", {rg_full[g], rg_empty[g]}, 1);
      end
      @(negedge clk);

      // fill non-periodic region, one extra push overflows
      b_txv = 1; b_sel = 0;
      for (int i = 0; i < 9; i++) begin b_txd = 32'hA000_0000 + i; tick(); end
      // fill periodic region via sel=1 (R8)
      b_sel = 1;
      for (int i = 0; i < 8; i++) begin b_txd = 32'hB000_0000 + i; tick(); end
      idle(); tick();
      chk(rg_used[2] == 8 && rg_used[1] == 8, "R8 region select", {rg_used[2], rg_used[1]}, 32'h0008_0008);
      // fill receive region plus one overflow
      l_rxv = 1;
      for (int i = 0; i < 17; i++) begin l_rxd = 32'hC000_0000 + i; tick(); end
      idle();
      // pop three np, push three more (wraps), then drain with one extra pop
      l_np = 1; repeat (3) tick(); idle();
      b_txv = 1; b_sel = 0;
      for (int i = 8; i < 11; i++) begin b_txd = 32'hA000_0000 + i; tick(); end
      idle();
      l_np = 1; repeat (9) tick(); idle();
      l_pt = 1; repeat (9) tick(); idle();
      // drain receive region
      b_rxp = 1; repeat (17) tick(); idle();
      // contention: every requester active at once
      b_sel = 0; b_txd = 32'hD000_0001; l_rxd = 32'hE000_0001;
      l_rxv = 1; l_np = 1; l_pt = 1; b_txv = 1; b_rxp = 1;
      repeat (3) tick();
      l_rxv = 0; repeat (3) tick();
      l_np = 0;  repeat (3) tick();
      l_pt = 0;  repeat (3) tick();
      b_txv = 0; repeat (3) tick();
      idle(); tick();
      // reconfigure np while it holds data (R9)
      b_txv = 1; b_sel = 0;
      for (int i = 0; i < 2; i++) begin b_txd = 32'hF000_0000 + i; tick(); end
      b_sel = 1; b_txd = 32'hF100_0000; tick();
      idle();
      cfg_np = {16'd4, 16'd40};
      tick(); tick();
      chk(rg_used[1] == 0, "R9 np cleared", rg_used[1], 0);
      chk(rg_free[1] == 4, "R9 np new depth", rg_free[1], 4);
      chk(rg_used[2] == 16'(q_pt.size()) && q_pt.size() == 1, "R9 pt kept", rg_used[2], 1);
      b_txv = 1; b_sel = 0;
      for (int i = 0; i < 5; i++) begin b_txd = 32'h9000_0000 + i; tick(); end
      idle();
      l_np = 1; repeat (5) tick(); idle();
      l_pt = 1; repeat (2) tick(); idle();
      tick(); tick();
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule